// File: doc/BRIEF.md
# Audio DAC Soft-Reset Sequencer

This block turns a software reset-control bit into the timed reset signals for a stereo audio DAC's digital path. The control bit is active low: writing 0 asks for the digital path to power down, writing 1 asks it to run. The block works on the master clock and measures its delays in sample frames. It counts rising edges of the frame clock after bringing them into the master clock domain. The configuration registers that hold the control bit are outside this block and are never cleared by it.

It drives three outputs. The first is an internal active-low reset for the digital path. It asserts a number of frames after the control bit falls, and releases a different number of frames after the bit rises. The second is a zero-data override. The sample path must send zeros while this override is high, so the analog stage rests at mid-scale. The third is a zero-detect flag. It rises at once when the control bit goes low and falls a fixed number of frames after the bit returns high. A hardware power-on reset starts the block in the held state. If the frame clock stops during reset, the block stays held and resumes counting when edges return.

Top module: `dac_softrst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `int_rst_n` is 0, `zero_force` is 1 and `zdet` is 1.
- R2: `zdet` is 1 at the first master clock edge at which `ctl_run` is sampled 0, and it stays 1 while `ctl_run` is 0.
- R3: Starting from normal operation, `int_rst_n` falls on the ASSERT_TICKS-th frame tick after `ctl_run` is sampled 0. The default is 4 ticks, which gives 3 to 4 frames.
- R4: Starting from the held state, `int_rst_n` rises on the RELEASE_TICKS-th frame tick after `ctl_run` is sampled 1. The default is 3 ticks, which gives 2 to 3 frames. `int_rst_n` rises only while `ctl_run` is 1.
- R5: `zdet` falls on the FLAG_TICKS-th frame tick after `ctl_run` returns to 1. The default is 2 ticks.
- R6: `zero_force` is 1 from the first edge at which `ctl_run` is sampled 0 until `int_rst_n` rises. It is 0 in normal operation, and it is always 1 while `int_rst_n` is 0.
- R7: If `ctl_run` changes while a delay is still pending, the count restarts from zero toward the new target. Aborting an assertion delay never pulses `int_rst_n` low. Aborting a release delay keeps `int_rst_n` low.
- R8: Without frame clock edges, no delay advances, however many master clock cycles pass. Counting resumes when edges return.
- R9: Each rising edge of `lrck` gives exactly one frame tick, through a SYNC_STAGES-flop synchronizer (default 2) and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low hardware power-on reset |
| ctl_run | input | 1 | Software reset-control bit: 0 requests reset, 1 requests run |
| lrck | input | 1 | Frame clock, asynchronous to `clk` |
| int_rst_n | output | 1 | Delayed internal reset for the digital path, active low |
| zero_force | output | 1 | Forces zero sample data when high |
| zdet | output | 1 | Zero-detect flag |

## Verification
The hardest case to reach is a control bit that reverses while a delay is half counted. A clean assert-then-release sequence never reaches the restart paths. The bench gets there by feeding a chosen number of whole frames and then flipping `ctl_run` mid-count, in both directions. It then checks that `int_rst_n` neither glitches nor releases early. The stopped-clock case is reached by holding `lrck` still for hundreds of master cycles with a release pending, then restarting it.

// File: rtl/dac_softrst_pkg.sv
// Shared types for the DAC soft-reset sequencer.
package dac_softrst_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,  // normal operation
        SEQ_ENTER = 2'd1,  // counting toward internal reset
        SEQ_HELD  = 2'd2,  // internal reset active
        SEQ_LEAVE = 2'd3   // counting toward release
    } seq_state_t;

endpackage

// File: rtl/frame_tick.sv
// Brings the asynchronous frame clock into the master clock domain and
// emits a one-cycle tick per rising edge.
// Assumes: lrck stays high and low for several clk periods each.
module frame_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    output logic tick
);
    logic [SYNC_STAGES:0] sh;

    // synchronizer chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], lrck};
    end

    // rising edge of the synchronized frame clock
    assign tick = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick lasted more than one cycle");

endmodule

// File: rtl/rst_seq_fsm.sv
// Frame-counted sequencer for the internal reset and zero-data override.
// Assumes: tick is a single-cycle pulse, ctl_run is synchronous to clk.
module rst_seq_fsm
    import dac_softrst_pkg::*;
#(
    parameter int ASSERT_TICKS  = 4,
    parameter int RELEASE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_run,
    input  logic tick,
    output logic int_rst_n,
    output logic zero_force
);
    localparam int MAXT = (ASSERT_TICKS > RELEASE_TICKS) ? ASSERT_TICKS : RELEASE_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] A_LAST = CW'(ASSERT_TICKS - 1);
    localparam logic [CW-1:0] R_LAST = CW'(RELEASE_TICKS - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          irst_q;

    // phase, frame counter and internal reset register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_HELD;
            cnt    <= '0;
            irst_q <= 1'b0;
        end else begin
            unique case (state)
                SEQ_RUN: begin
                    if (!ctl_run) begin
                        state <= SEQ_ENTER;
                        cnt   <= '0;
                    end
                end
                SEQ_ENTER: begin
                    if (ctl_run) begin
                        state <= SEQ_LEAVE;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (cnt == A_LAST) begin
                            state  <= SEQ_HELD;
                            cnt    <= '0;
                            irst_q <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                SEQ_HELD: begin
                    if (ctl_run) begin
                        state <= SEQ_LEAVE;
                        cnt   <= '0;
                    end
                end
                SEQ_LEAVE: begin
                    if (!ctl_run) begin
                        state <= SEQ_ENTER;
                        cnt   <= '0;
                    end else if (tick) begin
                        if (cnt == R_LAST) begin
                            state  <= SEQ_RUN;
                            cnt    <= '0;
                            irst_q <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_HELD;
            endcase
        end
    end

    assign int_rst_n  = irst_q;
    assign zero_force = (state != SEQ_RUN);

    p_force_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_rst_n |-> zero_force)
        else $error("zero override dropped while in reset");

    p_no_move_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(int_rst_n))
        else $error("internal reset moved without a frame tick");

    p_release_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rst_n) |-> $past(ctl_run))
        else $error("internal reset released while control bit low");

    p_assert_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst_n) |-> !$past(ctl_run))
        else $error("internal reset asserted while control bit high");

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXT))
        else $error("frame counter out of range");

endmodule

// File: rtl/zdet_flag.sv
// Zero-detect flag: set while the control bit is low, cleared a fixed
// number of frame ticks after it returns high.
// Assumes: tick is a single-cycle pulse.
module zdet_flag #(
    parameter int FLAG_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_run,
    input  logic tick,
    output logic zdet
);
    localparam int FW = $clog2(FLAG_TICKS + 1);
    localparam logic [FW-1:0] F_LAST = FW'(FLAG_TICKS - 1);

    logic          flag_q;
    logic [FW-1:0] fcnt;

    // flag register and its release counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
            fcnt   <= '0;
        end else if (!ctl_run) begin
            flag_q <= 1'b1;
            fcnt   <= '0;
        end else if (flag_q && tick) begin
            if (fcnt == F_LAST) begin
                flag_q <= 1'b0;
                fcnt   <= '0;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    assign zdet = flag_q;

    p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_run |=> zdet)
        else $error("flag not set after control bit low");

    p_flag_fall_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zdet) |-> ($past(tick) && $past(ctl_run)))
        else $error("flag cleared without a tick");

endmodule

// File: rtl/dac_softrst_seq.sv
// Top of the DAC soft-reset sequencer: frame tick extraction, reset
// sequencing and zero-detect flag.
// Assumes: ctl_run comes from a register in the clk domain; lrck is async.
module dac_softrst_seq #(
    parameter int SYNC_STAGES   = 2,
    parameter int ASSERT_TICKS  = 4,
    parameter int RELEASE_TICKS = 3,
    parameter int FLAG_TICKS    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_run,
    input  logic lrck,
    output logic int_rst_n,
    output logic zero_force,
    output logic zdet
);
    logic tick;

    frame_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .lrck  (lrck),
        .tick  (tick)
    );

    rst_seq_fsm #(.ASSERT_TICKS(ASSERT_TICKS), .RELEASE_TICKS(RELEASE_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_run    (ctl_run),
        .tick       (tick),
        .int_rst_n  (int_rst_n),
        .zero_force (zero_force)
    );

    zdet_flag #(.FLAG_TICKS(FLAG_TICKS)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_run (ctl_run),
        .tick    (tick),
        .zdet    (zdet)
    );

endmodule

// File: tb/tb_dac_softrst_seq.sv
module tb_dac_softrst_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_run = 1'b0;
    logic lrck = 1'b0;
    logic int_rst_n, zero_force, zdet;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_softrst_seq dut (
        .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .lrck(lrck),
        .int_rst_n(int_rst_n), .zero_force(zero_force), .zdet(zdet)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            lrck = 1'b1; clks(8);
            lrck = 1'b0; clks(8);
        end
    endtask

    task automatic test_power_on();
        rst_n = 1'b0; ctl_run = 1'b0; lrck = 1'b0;
        clks(3);
        chk("R1", "int_rst_n in reset", int_rst_n, 1'b0);
        chk("R1", "zero_force in reset", zero_force, 1'b1);
        chk("R1", "zdet in reset", zdet, 1'b1);
        rst_n = 1'b1; clks(1);
        chk("R1", "int_rst_n after reset", int_rst_n, 1'b0);
        chk("R1", "zdet after reset", zdet, 1'b1);
        frames(2);
        chk("R1", "held while ctl low", int_rst_n, 1'b0);
        chk("R2", "zdet held while ctl low", zdet, 1'b1);
    endtask

    task automatic test_release();
        ctl_run = 1'b1;
        frames(1);
        chk("R5", "zdet after 1 tick", zdet, 1'b1);
        frames(1);
        chk("R5", "zdet after 2 ticks", zdet, 1'b0);
        chk("R4", "int_rst_n after 2 ticks", int_rst_n, 1'b0);
        chk("R6", "zero_force during release", zero_force, 1'b1);
        frames(1);
        chk("R4", "int_rst_n after 3 ticks", int_rst_n, 1'b1);
        chk("R6", "zero_force in run", zero_force, 1'b0);
    endtask

    task automatic test_assert();
        ctl_run = 1'b0; clks(1);
        chk("R2", "zdet one clk after ctl low", zdet, 1'b1);
        chk("R6", "zero_force one clk after ctl low", zero_force, 1'b1);
        chk("R3", "int_rst_n not yet", int_rst_n, 1'b1);
        frames(3);
        chk("R3", "int_rst_n after 3 ticks", int_rst_n, 1'b1);
        frames(1);
        chk("R3", "int_rst_n after 4 ticks", int_rst_n, 1'b0);
        chk("R6", "zero_force in held", zero_force, 1'b1);
    endtask

    task automatic test_clock_stop();
        ctl_run = 1'b1;
        clks(300);
        chk("R8", "int_rst_n with lrck stopped", int_rst_n, 1'b0);
        chk("R8", "zdet with lrck stopped", zdet, 1'b1);
        chk("R8", "zero_force with lrck stopped", zero_force, 1'b1);
        frames(2);
        chk("R8", "zdet after restart", zdet, 1'b0);
        chk("R9", "no early release", int_rst_n, 1'b0);
        frames(1);
        chk("R8", "release after restart", int_rst_n, 1'b1);
    endtask

    task automatic test_abort_enter();
        bit glitch = 1'b0;
        ctl_run = 1'b0; clks(1);
        frames(2);
        ctl_run = 1'b1;
        for (int i = 0; i < 2; i++) begin
            lrck = 1'b1;
            for (int k = 0; k < 8; k++) begin @(negedge clk); if (!int_rst_n) glitch = 1'b1; end
            lrck = 1'b0;
            for (int k = 0; k < 8; k++) begin @(negedge clk); if (!int_rst_n) glitch = 1'b1; end
        end
        chk("R7", "no reset pulse on aborted entry", glitch, 1'b0);
        chk("R5", "zdet cleared after abort", zdet, 1'b0);
        chk("R7", "zero_force pending after abort", zero_force, 1'b1);
        frames(1);
        chk("R7", "zero_force cleared after restart count", zero_force, 1'b0);
        chk("R7", "int_rst_n stays high", int_rst_n, 1'b1);
    endtask

    task automatic test_abort_leave();
        ctl_run = 1'b0; clks(1);
        frames(4);
        chk("R3", "held before abort test", int_rst_n, 1'b0);
        ctl_run = 1'b1;
        frames(2);
        ctl_run = 1'b0; clks(1);
        frames(3);
        chk("R7", "int_rst_n low after aborted release", int_rst_n, 1'b0);
        chk("R7", "zdet high after aborted release", zdet, 1'b1);
        frames(1);
        ctl_run = 1'b1;
        frames(2);
        chk("R7", "count restarted, not released", int_rst_n, 1'b0);
        frames(1);
        chk("R4", "release after full count", int_rst_n, 1'b1);
    endtask

    task automatic test_hw_reset();
        rst_n = 1'b0; clks(2);
        rst_n = 1'b1;
        chk("R1", "int_rst_n after hw reset in run", int_rst_n, 1'b0);
        chk("R1", "zdet after hw reset in run", zdet, 1'b1);
        chk("R1", "zero_force after hw reset in run", zero_force, 1'b1);
        frames(3);
        chk("R4", "release after hw reset", int_rst_n, 1'b1);
    endtask

    initial begin
        test_power_on();
        test_release();
        test_assert();
        test_clock_stop();
        test_abort_enter();
        test_abort_leave();
        test_hw_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule